// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two binary32 operands in a two-stage pipeline and accepts a new pair on every cycle. The first stage classifies both operands, restores the implicit leading ones, forms the full 48-bit product of the two 24-bit significands, and sums the biased exponents with one bias taken off. The second stage normalizes the product by at most one place, rounds it in one of four selectable modes, checks the exponent range and packs the result.

Operands with a zero exponent field are treated as zero, and so are results whose exponent falls below the normal range. Three flags qualify each result: range exceeded, range fallen short, and invalid operation.

Top module: `fp32_mul`

## Requirements
- R1: A pair presented with `in_valid` high at a rising edge yields `out_valid` high exactly two rising edges later, in issue order, one result per pair. Reset clears `out_valid`.
- R2: For every result that is not invalid, the sign bit of `product` is the XOR of the two operand sign bits.
- R3: For finite normal operands, the result exponent is Ea + Eb − 127, plus one when the significand product is 2 or more. In that case the product is shifted right by one place. For example, 0x3F000000 × 0xBEE00000 gives 0xBE600000, and 0x3FC00000 × 0x3FC00000 gives 0x40100000.
- R4: `rmode` selects the rounding: 2'b00 rounds to nearest with ties to even, 2'b01 rounds toward zero, 2'b10 rounds toward +∞, and 2'b11 rounds toward −∞. The first discarded bit is the guard bit and the next is the round bit. The sticky bit is the OR of all lower product bits.
- R5: When rounding carries out of the significand, the significand becomes 1.0 and the exponent goes up by one. For example, 0x3FA1E58F × 0x3FCA6691 gives 0x40000000 under round-to-nearest and 0x3FFFFFFF under round-toward-zero.
- R6: A final biased exponent of 255 or more gives a signed infinity (exponent field all ones, fraction zero) with `ovf` set.
- R7: A final biased exponent of 0 or less gives a signed zero with `unf` set.
- R8: Any NaN operand, or zero times infinity, gives 0x7FC00000 with `inv` set.
- R9: An operand with a zero exponent field counts as zero, and a finite operand times infinity gives infinity. Both results carry the XOR sign, and neither raises a flag.
- R10: `ovf`, `unf` and `inv` are all low while `out_valid` is low. At most one of them is high at a time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair present |
| a | input | 32 | First binary32 operand |
| b | input | 32 | Second binary32 operand |
| rmode | input | 2 | Rounding mode select |
| out_valid | output | 1 | Result present |
| product | output | 32 | Packed binary32 result |
| ovf | output | 1 | Exponent range exceeded |
| unf | output | 1 | Result below normal range, flushed |
| inv | output | 1 | Invalid operation |

## Verification
The timing and sign properties assume that operands are sampled only when `in_valid` is high and that reset is held long enough to clear both stages. The bench drives inputs only at falling edges, holds `in_valid` low throughout reset, and keeps no more than one pair per cycle in flight. The vectors are chosen so that each rounding path meets a known exact product: a tie with an even kept bit, a tie with an odd kept bit, a tail above the halfway point, and a significand of all ones that carries out. The expected values therefore rest on integer arithmetic and not on a second multiplier.

// File: rtl/fp32_mul.sv
module fp32_mul (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] a,
  input  logic [31:0] b,
  input  logic [1:0]  rmode,
  output logic        out_valid,
  output logic [31:0] product,
  output logic        ovf,
  output logic        unf,
  output logic        inv
);
  localparam logic [1:0] CL_NORM = 2'd0, CL_ZERO = 2'd1, CL_INF = 2'd2, CL_BAD = 2'd3;
  localparam logic [31:0] QNAN = 32'h7FC00000;

  logic [7:0] ea, eb;
  logic       a_zero, b_zero, a_inf, b_inf, a_nan, b_nan;
  logic [1:0] cls_in;

  assign ea     = a[30:23];
  assign eb     = b[30:23];
  assign a_zero = (ea == 8'd0);
  assign b_zero = (eb == 8'd0);
  assign a_inf  = (&ea) && (a[22:0] == 23'd0);
  assign b_inf  = (&eb) && (b[22:0] == 23'd0);
  assign a_nan  = (&ea) && (a[22:0] != 23'd0);
  assign b_nan  = (&eb) && (b[22:0] != 23'd0);

  always_comb begin
    if (a_nan || b_nan || (a_inf && b_zero) || (a_zero && b_inf)) cls_in = CL_BAD;
    else if (a_inf || b_inf)                                       cls_in = CL_INF;
    else if (a_zero || b_zero)                                     cls_in = CL_ZERO;
    else                                                           cls_in = CL_NORM;
  end

  logic              s1_v, s1_sign;
  logic [47:0]       s1_prod;
  logic signed [9:0] s1_exp;
  logic [1:0]        s1_cls, s1_rm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0;
    end else begin
      s1_v    <= in_valid;
      s1_sign <= a[31] ^ b[31];
      s1_prod <= {24'd0, 1'b1, a[22:0]} * {24'd0, 1'b1, b[22:0]};
      s1_exp  <= $signed({2'b00, ea}) + $signed({2'b00, eb}) - 10'sd127;
      s1_cls  <= cls_in;
      s1_rm   <= rmode;
    end
  end

  logic              hi, g_bit, r_bit, st_bit, inexact, inc;
  logic [22:0]       kept, frac_r;
  logic [24:0]       rsum;
  logic signed [9:0] e_n, e_r;

  assign hi      = s1_prod[47];
  assign kept    = hi ? s1_prod[46:24] : s1_prod[45:23];
  assign g_bit   = hi ? s1_prod[23] : s1_prod[22];
  assign r_bit   = hi ? s1_prod[22] : s1_prod[21];
  assign st_bit  = hi ? (|s1_prod[21:0]) : (|s1_prod[20:0]);
  assign inexact = g_bit | r_bit | st_bit;
  assign e_n     = s1_exp + (hi ? 10'sd1 : 10'sd0);

  always_comb begin
    case (s1_rm)
      2'b00:   inc = g_bit & (r_bit | st_bit | kept[0]);
      2'b01:   inc = 1'b0;
      2'b10:   inc = ~s1_sign & inexact;
      default: inc = s1_sign & inexact;
    endcase
  end

  assign rsum   = {2'b01, kept} + {24'd0, inc};
  assign e_r    = e_n + (rsum[24] ? 10'sd1 : 10'sd0);
  assign frac_r = rsum[24] ? rsum[23:1] : rsum[22:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      product   <= 32'd0;
      {ovf, unf, inv} <= 3'b000;
    end else begin
      out_valid <= s1_v;
      {ovf, unf, inv} <= 3'b000;
      case (s1_cls)
        CL_BAD:  begin product <= QNAN; inv <= s1_v; end
        CL_INF:  product <= {s1_sign, 8'hFF, 23'd0};
        CL_ZERO: product <= {s1_sign, 31'd0};
        default: begin
          if (e_r >= 10'sd255) begin
            product <= {s1_sign, 8'hFF, 23'd0};
            ovf     <= s1_v;
          end else if (e_r <= 10'sd0) begin
            product <= {s1_sign, 31'd0};
            unf     <= s1_v;
          end else begin
            product <= {s1_sign, e_r[7:0], frac_r};
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/fp32_mul_chk.sv
module fp32_mul_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] a,
  input logic [31:0] b,
  input logic [1:0]  rmode,
  input logic        out_valid,
  input logic [31:0] product,
  input logic        ovf,
  input logic        unf,
  input logic        inv
);
  logic [1:0] cyc;
  always_ff @(posedge clk) begin
    if (!rst_n) cyc <= 2'd0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2) |-> (out_valid == $past(in_valid, 2))); // R1
  AST_SIGN_XOR: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2 && out_valid && !inv) |-> (product[31] == $past(a[31] ^ b[31], 2))); // R2
  AST_OVF_INF: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ovf) |-> (product[30:0] == 31'h7F800000)); // R6
  AST_UNF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && unf) |-> (product[30:0] == 31'd0)); // R7
  AST_INV_QNAN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && inv) |-> (product == 32'h7FC00000)); // R8
  AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !(ovf || unf || inv)); // R10
  AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ovf, unf, inv})); // R10
endmodule

bind fp32_mul fp32_mul_chk u_chk (.*);

// File: tb/tb_fp32_mul.sv
module tb_fp32_mul;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] a = 32'd0, b = 32'd0;
  logic [1:0]  rmode = 2'b00;
  logic        out_valid, ovf, unf, inv;
  logic [31:0] product;

  int total = 0, fails = 0, cyc = 0;
  logic [34:0] exp_q[$];
  int          cyc_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fp32_mul dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b), .rmode(rmode),
                .out_valid(out_valid), .product(product), .ovf(ovf), .unf(unf), .inv(inv));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // flags packed as {ovf,unf,inv}
  task automatic send(input logic [31:0] x, input logic [31:0] y, input logic [1:0] rm,
                      input logic [31:0] res, input logic [2:0] fl, input string tag);
    @(negedge clk);
    a = x; b = y; rmode = rm; in_valid = 1'b1;
    exp_q.push_back({fl, res});
    cyc_q.push_back(cyc);
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (!out_valid)
        chk({ovf, unf, inv} == 3'b000, "R10 flags idle", {61'd0, ovf, unf, inv}, 64'd0);
      else if (exp_q.size() == 0)
        chk(1'b0, "R1 unexpected result", 64'd1, 64'd0);
      else begin
        logic [34:0] e;
        int ic;
        string t;
        e = exp_q.pop_front();
        ic = cyc_q.pop_front();
        t = tag_q.pop_front();
        chk(cyc - ic == 2, "R1 latency", 64'(cyc - ic), 64'd2);
        chk({ovf, unf, inv, product} == e, t, {29'd0, ovf, unf, inv, product}, {29'd0, e});
      end
    end
  end

  initial begin
    #2000000;
    chk(1'b0, "watchdog", 64'd0, 64'd1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R1 reset valid", {63'd0, out_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && {ovf, unf, inv} == 3'b000, "R1 after reset",
        {60'd0, out_valid, ovf, unf, inv}, 64'd0);

    send(32'h3F000000, 32'hBEE00000, 2'b00, 32'hBE600000, 3'b000, "R3 R2 half times -0.4375");
    send(32'h3FC00000, 32'h3FC00000, 2'b00, 32'h40100000, 3'b000, "R3 normalize shift");
    send(32'h40400000, 32'hC0000000, 2'b00, 32'hC0C00000, 3'b000, "R2 R3 three times -2");
    send(32'h3F800001, 32'h3F800001, 2'b00, 32'h3F800002, 3'b000, "R4 nearest below half");
    send(32'h3F800001, 32'h3F800001, 2'b10, 32'h3F800003, 3'b000, "R4 up positive");
    send(32'h3F800001, 32'h3F800001, 2'b01, 32'h3F800002, 3'b000, "R4 toward zero");
    send(32'hBF800001, 32'h3F800001, 2'b11, 32'hBF800003, 3'b000, "R4 down negative");
    send(32'hBF800001, 32'h3F800001, 2'b10, 32'hBF800002, 3'b000, "R4 up negative");
    send(32'h3F800800, 32'h3F800800, 2'b00, 32'h3F801000, 3'b000, "R4 tie even kept");
    send(32'h3F800800, 32'h3F800800, 2'b10, 32'h3F801001, 3'b000, "R4 tie up");
    send(32'h3F800800, 32'h3F801800, 2'b00, 32'h3F802002, 3'b000, "R4 tie odd rounds up");
    send(32'h3F800800, 32'h3F801800, 2'b01, 32'h3F802001, 3'b000, "R4 tie odd truncated");
    send(32'h3FA1E58F, 32'h3FCA6691, 2'b00, 32'h40000000, 3'b000, "R5 carry out");
    send(32'h3FA1E58F, 32'h3FCA6691, 2'b01, 32'h3FFFFFFF, 3'b000, "R5 no carry truncate");
    send(32'h7F000000, 32'h40000000, 2'b00, 32'h7F800000, 3'b100, "R6 overflow");
    send(32'hFF000000, 32'h40000000, 2'b01, 32'hFF800000, 3'b100, "R6 overflow negative");
    send(32'h00800000, 32'h3F000000, 2'b00, 32'h00000000, 3'b010, "R7 underflow");
    send(32'h80800000, 32'h3F000000, 2'b00, 32'h80000000, 3'b010, "R7 underflow negative");
    send(32'h7FC00000, 32'h3F800000, 2'b00, 32'h7FC00000, 3'b001, "R8 nan operand");
    send(32'h3F800000, 32'hFF800001, 2'b00, 32'h7FC00000, 3'b001, "R8 signalling nan");
    send(32'h7F800000, 32'h00000000, 2'b00, 32'h7FC00000, 3'b001, "R8 inf times zero");
    send(32'h7F800000, 32'hC0000000, 2'b00, 32'hFF800000, 3'b000, "R9 inf times finite");
    send(32'h00000001, 32'h3F800000, 2'b00, 32'h00000000, 3'b000, "R9 denormal as zero");
    send(32'h80000000, 32'h40A00000, 2'b00, 32'h80000000, 3'b000, "R9 negative zero");
    @(negedge clk);
    in_valid = 1'b0;
    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0, "R1 all results", 64'(exp_q.size()), 64'd0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule